// File: doc/BRIEF.md
# Sequential Binary-to-BCD Converter

This block turns a 16-bit unsigned binary number into four packed decimal digits using the shift-and-add-3 method. It handles one binary bit per clock cycle, so each conversion occupies the engine for sixteen cycles. A caller presents an operand together with a one-cycle start strobe. The engine raises busy while it runs, then pulses done for a single cycle when the decimal result is on the output.

The decimal output and the overflow flag are registered separately from the working accumulator. They keep the last completed result until the next conversion finishes, so a display or other consumer can read them at any time. An operand above 9999 cannot fit in four digits. For such an operand the overflow flag is set with done, and the four digits show the operand's lowest four decimal places.

Top module: `dd_bcd_conv`

## Requirements
- R1: While reset is high and on the first cycle after it, busy_o, done_o, ovf_o and bcd_o are all zero.
- R2: bcd_o packs thousands in bits [15:12], hundreds in [11:8], tens in [7:4] and units in [3:0], each digit in plain 8-4-2-1 code. Together they equal the operand modulo 10000.
- R3: A start_i high on a clock edge while busy_o is low loads bin_i and sets busy_o from the next cycle on. This includes the cycle in which done_o is high.
- R4: A start_i while busy_o is high has no effect: the running conversion is neither restarted nor changed.
- R5: busy_o stays high for exactly 16 cycles after an accepted start. done_o rises in the cycle in which busy_o falls.
- R6: done_o is high for exactly one cycle per conversion. bcd_o and ovf_o change only in a cycle where done_o is high, and hold their values otherwise.
- R7: ovf_o is 1 together with done_o when the loaded operand exceeds 9999, and 0 otherwise.
- R8: Every 4-bit digit of bcd_o is in the range 0 to 9 at all times.
- R9: Changes of bin_i after the start edge do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a conversion of bin_i (taken only when idle) |
| bin_i | input | 16 | Unsigned binary operand |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| bcd_o | output | 16 | Four packed decimal digits of the last result |
| ovf_o | output | 1 | Last operand was above 9999 |

## Verification
The bench targets these corner cases:
- Digit carries such as 9, 99 and 999 rolling over. A misplaced or missing add-3 correction produces digit codes from 10 to 15 or wrong carries at these points.
- The 9999/10000 boundary and the top of the 16-bit range. A wrong overflow comparison flips ovf_o there, and a wrong truncation corrupts the low digits.
- A start held high through a whole conversion, and a new start issued in the done cycle. An engine that restarts while running, or that refuses back-to-back work, puts busy_o and done_o out of step with the cycle model.
- bin_i scrambled mid-run, and a reset in mid-conversion. These expose a datapath that samples the operand live, or a run that survives reset.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    localparam int unsigned DIG_W = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_t;

    function automatic int unsigned pow10(input int unsigned n);
        int unsigned r;
        r = 1;
        for (int unsigned i = 0; i < n; i++) r = r * 10;
        return r;
    endfunction

    function automatic logic [DIG_W-1:0] digit_fix(input logic [DIG_W-1:0] d);
        return (d > 4'd4) ? d + 4'd3 : d;
    endfunction

endpackage

// File: rtl/bcd_digit_adj.sv
module bcd_digit_adj
    import bcd_pkg::*;
#(
    parameter int unsigned NDIG = 4
) (
    input  logic [NDIG*DIG_W-1:0] acc_i,
    output logic [NDIG*DIG_W-1:0] acc_o
);

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        assign acc_o[g*DIG_W +: DIG_W] = digit_fix(acc_i[g*DIG_W +: DIG_W]);
    end

endmodule

// File: rtl/bcd_seq_ctrl.sv
module bcd_seq_ctrl
    import bcd_pkg::*;
#(
    parameter int unsigned STEPS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o,
    output logic load_o,
    output logic step_o,
    output logic last_o
);

    localparam int unsigned CNT_W = $clog2(STEPS + 1);

    seq_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;

    assign busy_o = (state_q == SEQ_RUN);
    assign load_o = start_i && !busy_o;
    assign step_o = busy_o;
    assign last_o = busy_o && (cnt_q == CNT_W'(STEPS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else if (load_o) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
        end else if (step_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (last_o) state_q <= SEQ_IDLE;
        end
    end

endmodule

// File: rtl/bcd_range_cmp.sv
module bcd_range_cmp
    import bcd_pkg::*;
#(
    parameter int unsigned BIN_W = 16,
    parameter int unsigned NDIG  = 4
) (
    input  logic [BIN_W-1:0] val_i,
    output logic             over_o
);

    localparam int unsigned LIMIT = pow10(NDIG) - 1;

    assign over_o = 32'(val_i) > LIMIT;

endmodule

// File: rtl/dd_bcd_conv.sv
module dd_bcd_conv
    import bcd_pkg::*;
#(
    parameter int unsigned BIN_W = 16,
    parameter int unsigned NDIG  = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [BIN_W-1:0]       bin_i,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [NDIG*DIG_W-1:0]  bcd_o,
    output logic                   ovf_o
);

    localparam int unsigned ACC_W = NDIG * DIG_W;

    logic             load, step, last, over_in;
    logic [BIN_W-1:0] opnd_q;
    logic [ACC_W-1:0] acc_q, acc_adj, acc_next;
    logic [ACC_W-1:0] bcd_q;
    logic             ovf_pend_q, ovf_q, done_q;

    bcd_seq_ctrl #(.STEPS(BIN_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .busy_o  (busy_o),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last)
    );

    bcd_range_cmp #(.BIN_W(BIN_W), .NDIG(NDIG)) u_cmp (
        .val_i  (bin_i),
        .over_o (over_in)
    );

    bcd_digit_adj #(.NDIG(NDIG)) u_adj (
        .acc_i (acc_q),
        .acc_o (acc_adj)
    );

    // correct digits first, then shift in the next operand bit
    assign acc_next = {acc_adj[ACC_W-2:0], opnd_q[BIN_W-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            opnd_q     <= '0;
            acc_q      <= '0;
            bcd_q      <= '0;
            ovf_pend_q <= 1'b0;
            ovf_q      <= 1'b0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load) begin
                opnd_q     <= bin_i;
                acc_q      <= '0;
                ovf_pend_q <= over_in;
            end else if (step) begin
                opnd_q <= {opnd_q[BIN_W-2:0], 1'b0};
                acc_q  <= acc_next;
                if (last) begin
                    bcd_q  <= acc_next;
                    ovf_q  <= ovf_pend_q;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign done_o = done_q;
    assign bcd_o  = bcd_q;
    assign ovf_o  = ovf_q;

endmodule

// File: rtl/dd_bcd_chk.sv
module dd_bcd_chk
    import bcd_pkg::*;
#(
    parameter int unsigned BIN_W = 16,
    parameter int unsigned NDIG  = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start_i,
    input logic                  busy_o,
    input logic                  done_o,
    input logic [NDIG*DIG_W-1:0] bcd_o,
    input logic                  ovf_o
);

    localparam int unsigned RC_W = $clog2(BIN_W + 1) + 1;

    logic [RC_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy_o) run_cnt <= '0;
        else                run_cnt <= run_cnt + 1'b1;
    end

    function automatic logic digits_ok(input logic [NDIG*DIG_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < int'(NDIG); i++)
            if (v[i*DIG_W +: DIG_W] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    // R3
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && run_cnt < RC_W'(BIN_W - 1)) |=> busy_o);

    // R5
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (run_cnt == RC_W'(BIN_W)));

    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R6
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(bcd_o) && $stable(ovf_o)));

    // R8
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
        digits_ok(bcd_o));

endmodule

bind dd_bcd_conv dd_bcd_chk #(.BIN_W(BIN_W), .NDIG(NDIG)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .bcd_o   (bcd_o),
    .ovf_o   (ovf_o)
);

// File: tb/sim_dd_bcd_conv.sv
`timescale 1ns/1ps
module sim_dd_bcd_conv;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] bin_i = '0;
    logic        busy_o, done_o, ovf_o;
    logic [15:0] bcd_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #4 clk = ~clk;   // 125 MHz

    dd_bcd_conv u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .bin_i(bin_i),
        .busy_o(busy_o), .done_o(done_o), .bcd_o(bcd_o), .ovf_o(ovf_o)
    );

    // behavioural reference
    bit          m_busy = 0, m_done = 0, m_ovf = 0;
    int          m_left = 0;
    int          m_op = 0;
    logic [15:0] m_bcd = '0;

    function automatic logic [15:0] to_dec(input int v);
        int r;
        r = v % 10000;
        return {4'((r / 1000) % 10), 4'((r / 100) % 10), 4'((r / 10) % 10), 4'(r % 10)};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_busy = 0; m_done = 0; m_ovf = 0; m_left = 0; m_bcd = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_left--;
                if (m_left == 0) begin
                    m_busy = 0;
                    m_done = 1;
                    m_bcd  = to_dec(m_op);
                    m_ovf  = (m_op > 9999);
                end
            end else if (start_i) begin
                m_busy = 1;
                m_left = 16;
                m_op   = int'(bin_i);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
        end
    endtask

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(busy_o == m_busy, "R3/R4/R5 busy", int'(busy_o), int'(m_busy));
            chk(done_o == m_done, "R5/R6 done", int'(done_o), int'(m_done));
            chk(bcd_o == m_bcd, "R2/R6/R9 bcd", int'(bcd_o), int'(m_bcd));
            chk(ovf_o == m_ovf, "R7 ovf", int'(ovf_o), int'(m_ovf));
            if (done_o) begin
                // R8: every digit in 0..9
                chk((bcd_o[15:12] < 10) && (bcd_o[11:8] < 10) && (bcd_o[7:4] < 10) && (bcd_o[3:0] < 10),
                    "R8 digit range", int'(bcd_o), int'(m_bcd));
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc == 190000) begin
            errors++; checks++;
            $display("FAIL R5 watchdog: actual=%0d expected=<190000 cycles", cyc);
            summary();
        end
    end

    // poke=1 keeps start high and scrambles bin_i during the run (R4, R9)
    task automatic run_one(input int v, input bit poke);
        @(negedge clk);
        start_i = 1'b1;
        bin_i   = 16'(v);
        @(negedge clk);
        start_i = poke;
        bin_i   = ~16'(v);
        repeat (15) @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R1: outputs zero during reset
        chk(busy_o == 0 && done_o == 0 && bcd_o == 0 && ovf_o == 0, "R1 reset", int'(bcd_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && bcd_o == 0 && ovf_o == 0, "R1 after reset", int'(bcd_o), 0);

        for (int v = 0; v < 2048; v++) run_one(v, v[0]);
        for (int v = 9980; v <= 10020; v++) run_one(v, v[1]);
        for (int v = 65500; v <= 65535; v++) run_one(v, v[0]);
        for (int v = 2048; v < 65500; v += 17) run_one(v, v[2]);

        // reset in mid-conversion (R1)
        @(negedge clk);
        start_i = 1'b1; bin_i = 16'd4321;
        @(negedge clk);
        start_i = 1'b0;
        repeat (6) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy_o == 0 && done_o == 0 && bcd_o == 0, "R1 mid-run reset", int'(busy_o), 0);
        run_one(9999, 1'b0);
        run_one(10000, 1'b1);
        repeat (3) @(negedge clk);
        summary();
    end

endmodule